// File: doc/BRIEF.md
# Ethernet Status LED Driver

This block turns the status of an Ethernet port into four active-low LED pins. Its inputs are link state (up or down), a 2-bit speed code, a duplex flag, and single-cycle pulses that mark transmit and receive packets. A 2-bit map select picks one of four assignments of functions to the pins. There are three kinds of function. A plain link or duplex indicator is lit while its condition holds. An activity indicator is dark at rest and blinks while traffic flows. A combined link/activity indicator is lit steadily while the link is up and idle, and blinks while traffic flows.

A blink cycle has a dark phase and then a lit phase. Each phase lasts a parameterised number of milliseconds, 40 by default. The block turns that time into clock cycles from the clock frequency parameter. A cycle that has started always runs to its end. Packets seen during a cycle do not restart it; they only cause one more full cycle when it ends. A power-down input turns every pin dark. When no map selection has been loaded, the block uses the map that shows link/activity per speed.

Top module: `ledStatusDriver`

## Requirements
- R1: After reset, and on the first cycle after reset is released, all four pins `ledN` read 1 (dark). A pin is lit when it reads 0.
- R2: Speed codes are 00 = 10 Mb/s, 01 = 100 Mb/s, 10 = 1000 Mb/s and 11 = none. A per-speed link indicator is lit only while `linkUp` is 1 and the speed code matches. Any change on the status inputs reaches the pins one clock later.
- R3: An activity indicator is dark at rest. A pulse that is sampled at edge E0 with the channel idle starts a cycle of P = CLK_HZ/1000*PHASE_MS clocks dark (pins change from edge E0+1), then P clocks lit, then a return to dark.
- R4: A pulse that arrives during a running cycle does not restart it. When the cycle ends, one more full dark/lit cycle follows with no gap.
- R5: A link/activity indicator is dark with no matching link. It is lit steadily with link and no traffic, and it follows the dark/lit cycle of the combined transmit-or-receive channel during traffic.
- R6: Map 00 drives ledN[0] = transmit-or-receive activity, ledN[1] = link at 100, ledN[2] = link at 10, ledN[3] = link at 1000.
- R7: Map 01 drives ledN[0] = link/activity for 10 or 1000, ledN[1] = link/activity for 100 or 1000, ledN[2] = full duplex, ledN[3] = link at 1000.
- R8: Map 10 drives ledN[0] = transmit activity, ledN[1] = link at any speed, ledN[2] = receive activity, ledN[3] = full duplex.
- R9: Map 11 drives ledN[0], ledN[1] and ledN[3] as link/activity for 10, 100 and 1000, and ledN[2] = full duplex. Map 11 is used whenever `mapValid` is 0, whatever `mapSel` holds.
- R10: While `powerDown` is 1, all pins read 1 from the next clock on, whatever the traffic. When it is released, the pins return to the selected map one clock later.
- R11: The full-duplex indicator is lit only while `linkUp` and `fullDuplex` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| linkUp | input | 1 | Link established |
| speedSel | input | 2 | Speed code: 00 = 10, 01 = 100, 10 = 1000, 11 = none |
| fullDuplex | input | 1 | Full duplex negotiated |
| txPulse | input | 1 | One-cycle pulse per transmitted packet |
| rxPulse | input | 1 | One-cycle pulse per received packet |
| mapSel | input | 2 | Pin-function map select |
| mapValid | input | 1 | mapSel has been loaded; when 0, map 11 is used |
| powerDown | input | 1 | Forces all pins dark |
| ledN | output | 4 | Active-low LED pins |

## Verification
Most state in this block lives in the three blink phase counters. A wrong counter shows up at the pins as a dark or lit phase whose length is not P, or as a cycle that restarts when a second pulse arrives. Either fault appears within one blink period, so the bench checks the pin level in the clock just before and just after each expected phase boundary. A wrong map decode or a lost power-down override shows up in the very next clock after the status inputs change, and the bench checks every static case at that clock.

// File: rtl/ledStatusPkg.sv
package ledStatusPkg;

  localparam int NUM_LEDS = 4;
  localparam int NUM_CH   = 3;
  localparam int CH_TX    = 0;
  localparam int CH_RX    = 1;
  localparam int CH_ANY   = 2;

  typedef enum logic [1:0] {
    SPD_10   = 2'b00,
    SPD_100  = 2'b01,
    SPD_1000 = 2'b10,
    SPD_NONE = 2'b11
  } speedT;

  typedef enum logic [1:0] {
    MAP_ACT_SPEED = 2'b00,
    MAP_COMBO     = 2'b01,
    MAP_SPLIT     = 2'b10,
    MAP_LINKACT   = 2'b11
  } mapT;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_DARK = 2'b01,
    PH_LIT  = 2'b10
  } phaseT;

  // strobes from control to datapath, one bit per activity channel
  typedef struct packed {
    logic [NUM_CH-1:0] darkPhase;
    logic [NUM_CH-1:0] litPhase;
  } blinkStrobesT;

endpackage

// File: rtl/ledBlinker.sv
module ledBlinker
  import ledStatusPkg::*;
#(
  parameter int PHASE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic actPulse,
  output logic darkPhase,
  output logic litPhase
);

  localparam int CW = (PHASE_CYC > 2) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

  phaseT         phase;
  logic [CW-1:0] cnt;
  logic          pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      pend  <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          cnt  <= '0;
          pend <= 1'b0;
          if (actPulse) phase <= PH_DARK;
        end
        PH_DARK: begin
          pend <= pend | actPulse;
          if (cnt == LAST) begin
            phase <= PH_LIT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_LIT: begin
          if (cnt == LAST) begin
            cnt   <= '0;
            pend  <= 1'b0;
            phase <= (pend | actPulse) ? PH_DARK : PH_IDLE;
          end else begin
            cnt  <= cnt + 1'b1;
            pend <= pend | actPulse;
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
          pend  <= 1'b0;
        end
      endcase
    end
  end

  assign darkPhase = (phase == PH_DARK);
  assign litPhase  = (phase == PH_LIT);

  // R3: the lit phase is only ever entered from the dark phase
  a_r3_lit_follows_dark: assert property (@(posedge clk) disable iff (rst)
    $rose(litPhase) |-> $past(darkPhase));

  // R3: a cycle only finishes from its lit phase
  a_r3_idle_after_lit: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && $past(phase) != PH_IDLE) |-> $past(phase) == PH_LIT);

  // R4: a pulse inside a running phase never resets its count
  a_r4_count_keeps_running: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DARK && $past(phase) == PH_DARK) |-> cnt == $past(cnt) + 1'b1);

endmodule

// File: rtl/ledCtrl.sv
module ledCtrl
  import ledStatusPkg::*;
#(
  parameter int PHASE_CYC = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         txPulse,
  input  logic         rxPulse,
  output blinkStrobesT strobes
);

  logic [NUM_CH-1:0] chAct;
  logic [NUM_CH-1:0] chDark;
  logic [NUM_CH-1:0] chLit;

  assign chAct[CH_TX]  = txPulse;
  assign chAct[CH_RX]  = rxPulse;
  assign chAct[CH_ANY] = txPulse | rxPulse;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ledBlinker #(.PHASE_CYC(PHASE_CYC)) blink_i (
      .clk      (clk),
      .rst      (rst),
      .actPulse (chAct[c]),
      .darkPhase(chDark[c]),
      .litPhase (chLit[c])
    );
  end

  assign strobes.darkPhase = chDark;
  assign strobes.litPhase  = chLit;

endmodule

// File: rtl/ledDatapath.sv
module ledDatapath
  import ledStatusPkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                linkUp,
  input  logic [1:0]          speedSel,
  input  logic                fullDuplex,
  input  logic [1:0]          mapSel,
  input  logic                mapValid,
  input  logic                powerDown,
  input  blinkStrobesT        strobes,
  output logic [NUM_LEDS-1:0] ledN
);

  speedT spd;
  mapT   effMap;
  logic  lnk10, lnk100, lnk1000, dupOn;
  logic  anyDark, actAny, actTx, actRx;
  logic [NUM_LEDS-1:0] lit;

  assign spd    = speedT'(speedSel);
  assign effMap = mapValid ? mapT'(mapSel) : MAP_LINKACT;

  assign lnk10   = linkUp && (spd == SPD_10);
  assign lnk100  = linkUp && (spd == SPD_100);
  assign lnk1000 = linkUp && (spd == SPD_1000);
  assign dupOn   = linkUp && fullDuplex;

  assign anyDark = strobes.darkPhase[CH_ANY];
  assign actAny  = strobes.litPhase[CH_ANY];
  assign actTx   = strobes.litPhase[CH_TX];
  assign actRx   = strobes.litPhase[CH_RX];

  always_comb begin
    lit = '0;
    unique case (effMap)
      MAP_ACT_SPEED: lit = {lnk1000, lnk10, lnk100, actAny};
      MAP_COMBO:     lit = {lnk1000, dupOn,
                            (lnk100 | lnk1000) & ~anyDark,
                            (lnk10  | lnk1000) & ~anyDark};
      MAP_SPLIT:     lit = {dupOn, actRx, linkUp, actTx};
      MAP_LINKACT:   lit = {lnk1000 & ~anyDark, dupOn,
                            lnk100 & ~anyDark, lnk10 & ~anyDark};
      default:       lit = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            ledN <= '1;
    else if (powerDown) ledN <= '1;
    else                ledN <= ~lit;
  end

  // R3: each channel is in at most one phase at a time
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    a_r3_phase_exclusive: assert property (@(posedge clk) disable iff (rst)
      $onehot0({strobes.darkPhase[c], strobes.litPhase[c]}));
  end

  // R10: power-down darkens every pin on the next clock
  a_r10_dark_in_powerdown: assert property (@(posedge clk) disable iff (rst)
    powerDown |=> (ledN == '1));

  // R2: without link, all speed indicators of map 00 stay dark
  a_r2_no_link_dark: assert property (@(posedge clk) disable iff (rst)
    (!linkUp && effMap == MAP_ACT_SPEED) |=> (ledN[3:1] == 3'b111));

  // R5: link/activity pins are dark without link
  a_r5_linkact_needs_link: assert property (@(posedge clk) disable iff (rst)
    (!linkUp && effMap == MAP_LINKACT) |=> (ledN[0] && ledN[1] && ledN[3]));

  // R11: the duplex pin is dark without link
  a_r11_duplex_needs_link: assert property (@(posedge clk) disable iff (rst)
    (!linkUp && effMap == MAP_LINKACT) |=> ledN[2]);

endmodule

// File: rtl/ledStatusDriver.sv
module ledStatusDriver
  import ledStatusPkg::*;
#(
  parameter int CLK_HZ   = 125_000_000,
  parameter int PHASE_MS = 40
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       linkUp,
  input  logic [1:0] speedSel,
  input  logic       fullDuplex,
  input  logic       txPulse,
  input  logic       rxPulse,
  input  logic [1:0] mapSel,
  input  logic       mapValid,
  input  logic       powerDown,
  output logic [3:0] ledN
);

  localparam int PHASE_CYC = (CLK_HZ / 1000) * PHASE_MS;

  blinkStrobesT strobes;

  ledCtrl #(.PHASE_CYC(PHASE_CYC)) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .txPulse(txPulse),
    .rxPulse(rxPulse),
    .strobes(strobes)
  );

  ledDatapath dp_i (
    .clk       (clk),
    .rst       (rst),
    .linkUp    (linkUp),
    .speedSel  (speedSel),
    .fullDuplex(fullDuplex),
    .mapSel    (mapSel),
    .mapValid  (mapValid),
    .powerDown (powerDown),
    .strobes   (strobes),
    .ledN      (ledN)
  );

endmodule

// File: tb/ledStatusDriver_tb.sv
module ledStatusDriver_tb_top;

  localparam int P = 100; // CLK_HZ 50_000 with 2 ms phases

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       linkUp = 1'b0;
  logic [1:0] speedSel = 2'b00;
  logic       fullDuplex = 1'b0;
  logic       txPulse = 1'b0;
  logic       rxPulse = 1'b0;
  logic [1:0] mapSel = 2'b00;
  logic       mapValid = 1'b1;
  logic       powerDown = 1'b0;
  logic [3:0] ledN;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int         due;
    logic [3:0] val;
    string      req;
  } expT;

  expT q[$];
  expT it;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ledStatusDriver #(.CLK_HZ(50_000), .PHASE_MS(2)) dut_i (
    .clk(clk), .rst(rst), .linkUp(linkUp), .speedSel(speedSel),
    .fullDuplex(fullDuplex), .txPulse(txPulse), .rxPulse(rxPulse),
    .mapSel(mapSel), .mapValid(mapValid), .powerDown(powerDown), .ledN(ledN)
  );

  // driver side: queue an expected pin vector dly cycles from now
  task automatic expectIn(input int dly, input logic [3:0] v, input string req);
    expT e;
    int pos;
    e.due = cyc + dly;
    e.val = v;
    e.req = req;
    pos = q.size();
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].due > e.due) begin
        pos = i;
        break;
      end
    end
    q.insert(pos, e);
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setStatus(input logic lk, input logic [1:0] sp, input logic dp,
                           input logic [1:0] mp, input logic mv,
                           input logic [3:0] exp, input string req);
    linkUp = lk; speedSel = sp; fullDuplex = dp; mapSel = mp; mapValid = mv;
    expectIn(1, exp, req);
    waitCyc(3);
  endtask

  task automatic pulseTx();
    txPulse = 1'b1;
    @(negedge clk);
    txPulse = 1'b0;
  endtask

  task automatic pulseRx();
    rxPulse = 1'b1;
    @(negedge clk);
    rxPulse = 1'b0;
  endtask

  // monitor side: compare due items away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      it = q.pop_front();
      checks++;
      if (ledN !== it.val) begin
        errors++;
        $display("FAIL %s: ledN=%b expected %b at cycle %0d", it.req, ledN, it.val, cyc);
      end
    end
  end

  initial begin
    waitCyc(3);
    rst = 1'b0;
    expectIn(0, 4'b1111, "R1");       // R1 reset state
    expectIn(1, 4'b1111, "R1");       // R1 first cycle after release
    waitCyc(3);

    // R6 / R2: map 00 speed indicators
    setStatus(1, 2'b01, 1, 2'b00, 1, 4'b1101, "R6");
    setStatus(1, 2'b00, 1, 2'b00, 1, 4'b1011, "R2");
    setStatus(1, 2'b10, 1, 2'b00, 1, 4'b0111, "R2");
    setStatus(1, 2'b11, 1, 2'b00, 1, 4'b1111, "R2");
    setStatus(0, 2'b10, 1, 2'b00, 1, 4'b1111, "R2");

    // R6 / R3: receive traffic blinks ledN[0] in map 00
    setStatus(1, 2'b01, 1, 2'b00, 1, 4'b1101, "R6");
    expectIn(2,       4'b1101, "R3");
    expectIn(P + 1,   4'b1101, "R3");
    expectIn(P + 2,   4'b1100, "R3");
    expectIn(2*P + 1, 4'b1100, "R3");
    expectIn(2*P + 2, 4'b1101, "R3");
    pulseRx();
    waitCyc(2*P + 50);

    // R7 / R11: map 01
    setStatus(1, 2'b10, 1, 2'b01, 1, 4'b0000, "R7");
    setStatus(1, 2'b01, 0, 2'b01, 1, 4'b1101, "R11");
    setStatus(1, 2'b00, 1, 2'b01, 1, 4'b1010, "R7");
    expectIn(2,     4'b1011, "R7");
    expectIn(P + 2, 4'b1010, "R7");
    pulseTx();
    waitCyc(2*P + 50);

    // R8 / R3: map 10 split activity
    setStatus(1, 2'b00, 1, 2'b10, 1, 4'b0101, "R8");
    expectIn(2,       4'b0101, "R3");
    expectIn(P + 2,   4'b0100, "R3");
    expectIn(2*P + 1, 4'b0100, "R3");
    expectIn(2*P + 2, 4'b0101, "R3");
    pulseTx();
    waitCyc(2*P + 50);
    expectIn(P + 2, 4'b0001, "R8");
    pulseRx();
    waitCyc(2*P + 50);
    setStatus(0, 2'b00, 1, 2'b10, 1, 4'b1111, "R11");

    // R4: second pulse mid-cycle extends, never restarts
    setStatus(1, 2'b00, 1, 2'b10, 1, 4'b0101, "R4");
    expectIn(P + 2,   4'b0100, "R4");
    expectIn(P + 51,  4'b0100, "R4");
    expectIn(2*P + 2, 4'b0101, "R4");
    expectIn(3*P + 2, 4'b0100, "R4");
    expectIn(4*P + 1, 4'b0100, "R4");
    expectIn(4*P + 2, 4'b0101, "R4");
    pulseTx();
    waitCyc(49);
    pulseTx();
    waitCyc(4*P + 50);

    // R9 / R5: default map when not loaded, link/activity blink
    setStatus(1, 2'b01, 1, 2'b00, 0, 4'b1001, "R9");
    expectIn(2,       4'b1011, "R5");
    expectIn(P + 1,   4'b1011, "R5");
    expectIn(P + 2,   4'b1001, "R5");
    expectIn(2*P + 2, 4'b1001, "R5");
    pulseTx();
    waitCyc(2*P + 50);
    setStatus(1, 2'b01, 1, 2'b11, 1, 4'b1001, "R9");
    setStatus(0, 2'b01, 1, 2'b11, 1, 4'b1111, "R5");

    // R10: power-down
    setStatus(1, 2'b10, 1, 2'b11, 1, 4'b0011, "R10");
    powerDown = 1'b1;
    expectIn(1, 4'b1111, "R10");
    expectIn(P + 3, 4'b1111, "R10");
    waitCyc(1);
    pulseTx();
    waitCyc(2*P + 50);
    powerDown = 1'b0;
    expectIn(1, 4'b0011, "R10");
    waitCyc(3);

    // R1: reset in the middle of a run
    rst = 1'b1;
    expectIn(1, 4'b1111, "R1");
    waitCyc(3);
    rst = 1'b0;
    waitCyc(5);

    if (q.size() != 0) begin
      errors++;
      $display("FAIL queue: %0d expectations left, expected 0", q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule